// File: doc/BRIEF.md
# Cartridge Bank Mapping Controller

This block sits between a 16-bit CPU bus and the storage on a plug-in cartridge. It watches bus writes to the read-only code area, which the storage ignores, and uses them to update three small control registers: the switchable ROM bank, the external-window enable and the external-window select. From these registers and the live CPU address it forms the physical ROM address for the 32 KiB code area (0x0000-0x7FFF), and the physical RAM address for the 8 KiB external window (0xA000-0xBFFF).

One select register decides what the external window reaches. It can point at one of eight 8 KiB RAM banks, or at one of five clock registers. When a clock register is selected, every address in the window reaches that one register. The clock keeps its own time outside this block. The mapper only names the register to reach and pulses an access strobe. A window access that reaches nothing raises an open-bus flag, so the bus reads 0xFF. The ROM and RAM arrays are outside the block.

Top module: `cbm_mapper`

## Requirements
- R1: After reset the switchable ROM bank is 1, the select register is 0 (RAM bank 0) and the external window is disabled.
- R2: A read in 0x0000-0x3FFF raises rom_cs and drives rom_addr = {7'd0, cpu_addr[13:0]}, regardless of the bank register.
- R3: A write to 0x2000-0x3FFF loads cpu_wdata[6:0] into the ROM bank register, and bit 7 is ignored. A read in 0x4000-0x7FFF then drives rom_addr = {bank, cpu_addr[13:0]}. Every nonzero value, including 0x20, 0x40 and 0x60, reaches its own bank.
- R4: A ROM bank value of 0 selects bank 1.
- R5: A write to 0x0000-0x1FFF enables the external window when cpu_wdata[3:0] is 4'hA and disables it for any other value. The upper nibble is ignored.
- R6: A write to 0x4000-0x5FFF loads cpu_wdata[3:0] into the select register. While the window is enabled and the select is 0-7, a read or write in 0xA000-0xBFFF raises ram_en with ram_addr = {select[2:0], cpu_addr[12:0]}.
- R7: While the window is enabled and the select is 8-12, a read or write at any address in 0xA000-0xBFFF raises rtc_stb with rtc_idx = select - 8, and keeps ram_en low.
- R8: A window read that is not served, because the window is disabled or the select is 13-15, raises xw_ff, which means the bus reads 0xFF. In that case ram_en and rtc_stb stay low, and window writes reach nothing.
- R9: Writes to 0x6000-0x7FFF and to 0xA000-0xBFFF leave the ROM bank, the enable and the select unchanged.
- R10: Outside a read (for ROM) or a read or write (for the window), rom_cs, ram_en, rtc_stb and xw_ff are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| cpu_rd | input | 1 | Read strobe |
| rom_cs | output | 1 | ROM access in 0x0000-0x7FFF |
| rom_addr | output | 21 | Physical ROM byte address |
| ram_en | output | 1 | RAM access in the external window |
| ram_addr | output | 16 | Physical RAM byte address |
| rtc_idx | output | 3 | Index of the selected clock register (0-4) |
| rtc_stb | output | 1 | Clock register access in the external window |
| xw_ff | output | 1 | Window read not served; the bus reads 0xFF |

## Verification
The ROM bank register is swept over all 128 values, each probed at both ends of the switchable area. This separates a correct bank path from one that remaps zero wrongly or folds 0x20, 0x40 and 0x60. The enable key is tried with all sixteen low nibbles under changing upper nibbles, which exposes a decode that looks at too many or too few bits. All sixteen select values are probed at three window addresses with both reads and writes. This separates the RAM, clock-register and open-bus routes and their edges at 7/8 and 12/13. Writes into the latch area and into the window are followed by probes showing that the mapping is unchanged.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  // Read-side regions of the 16-bit CPU map
  typedef enum logic [1:0] {
    RGN_ROM_FIX = 2'd0,
    RGN_ROM_SW  = 2'd1,
    RGN_XWIN    = 2'd2,
    RGN_OTHER   = 2'd3
  } region_e;

  // Control register targets of writes into the code area
  typedef enum logic [2:0] {
    WT_ENABLE  = 3'd0,
    WT_ROMBANK = 3'd1,
    WT_SELECT  = 3'd2,
    WT_LATCH   = 3'd3,
    WT_NONE    = 3'd4
  } wtarget_e;

  // Route chosen by the select register
  typedef enum logic [1:0] {
    SK_RAM = 2'd0,
    SK_RTC = 2'd1,
    SK_OFF = 2'd2
  } selkind_e;

  localparam logic [3:0] ENABLE_KEY = 4'hA;

  function automatic region_e f_region(input logic [15:0] a);
    if (a[15:14] == 2'b00)      return RGN_ROM_FIX;
    else if (a[15:14] == 2'b01) return RGN_ROM_SW;
    else if (a[15:13] == 3'b101) return RGN_XWIN;
    else                        return RGN_OTHER;
  endfunction

  function automatic wtarget_e f_wtarget(input logic [15:0] a);
    if (a[15]) return WT_NONE;
    case (a[14:13])
      2'b00:   return WT_ENABLE;
      2'b01:   return WT_ROMBANK;
      2'b10:   return WT_SELECT;
      default: return WT_LATCH;
    endcase
  endfunction

  function automatic logic f_enable_key(input logic [7:0] d);
    return d[3:0] == ENABLE_KEY;
  endfunction

endpackage

// File: rtl/cbm_wdec.sv
module cbm_wdec
  import cbm_pkg::*;
(
  input  logic [15:0] cpu_addr,
  input  logic        cpu_wr,
  output logic        we_enable,
  output logic        we_rombank,
  output logic        we_select,
  output logic        we_latch
);

  wtarget_e tgt;

  always_comb begin
    tgt        = f_wtarget(cpu_addr);
    we_enable  = 1'b0;
    we_rombank = 1'b0;
    we_select  = 1'b0;
    we_latch   = 1'b0;
    if (cpu_wr) begin
      case (tgt)
        WT_ENABLE:  we_enable  = 1'b1;
        WT_ROMBANK: we_rombank = 1'b1;
        WT_SELECT:  we_select  = 1'b1;
        WT_LATCH:   we_latch   = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/cbm_regs.sv
module cbm_regs #(
  parameter int ROM_BANK_W = 7,
  parameter int SEL_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            wdata,
  input  logic                  we_enable,
  input  logic                  we_rombank,
  input  logic                  we_select,
  output logic [ROM_BANK_W-1:0] rom_bank_eff,
  output logic [SEL_W-1:0]      sel_q,
  output logic                  xw_enable_q
);

  import cbm_pkg::*;

  logic [ROM_BANK_W-1:0] rom_bank_raw_q;

  // Bank zero in the switchable area is steered to bank one
  function automatic logic [ROM_BANK_W-1:0] f_bank_fix(input logic [ROM_BANK_W-1:0] raw);
    if (raw == '0) return {{(ROM_BANK_W-1){1'b0}}, 1'b1};
    return raw;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_bank_raw_q <= {{(ROM_BANK_W-1){1'b0}}, 1'b1};
      sel_q          <= '0;
      xw_enable_q    <= 1'b0;
    end else begin
      if (we_rombank) rom_bank_raw_q <= wdata[ROM_BANK_W-1:0];
      if (we_select)  sel_q          <= wdata[SEL_W-1:0];
      if (we_enable)  xw_enable_q    <= f_enable_key(wdata);
    end
  end

  assign rom_bank_eff = f_bank_fix(rom_bank_raw_q);

endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate #(
  parameter int ROM_BANK_W  = 7,
  parameter int ROM_PAGE_AW = 14,
  parameter int RAM_BANK_W  = 3,
  parameter int RAM_PAGE_AW = 13,
  parameter int SEL_W       = 4,
  parameter int RTC_REGS    = 5,
  localparam int ROM_AW     = ROM_BANK_W + ROM_PAGE_AW,
  localparam int RAM_AW     = RAM_BANK_W + RAM_PAGE_AW,
  localparam int RTC_IDX_W  = (RTC_REGS > 1) ? $clog2(RTC_REGS) : 1
) (
  input  logic [15:0]           cpu_addr,
  input  logic                  cpu_wr,
  input  logic                  cpu_rd,
  input  logic [ROM_BANK_W-1:0] rom_bank_eff,
  input  logic [SEL_W-1:0]      sel_q,
  input  logic                  xw_enable_q,
  output logic                  rom_cs,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  ram_en,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic [RTC_IDX_W-1:0]  rtc_idx,
  output logic                  rtc_stb,
  output logic                  xw_ff,
  output logic                  xw_hit
);

  import cbm_pkg::*;

  localparam int RAM_BANKS = 1 << RAM_BANK_W;
  localparam int RTC_BASE  = RAM_BANKS;
  localparam int RTC_LAST  = RTC_BASE + RTC_REGS - 1;

  region_e  rgn;
  selkind_e kind;
  logic     any_acc;

  function automatic selkind_e f_kind(input logic [SEL_W-1:0] s);
    if (int'(s) < RAM_BANKS)                          return SK_RAM;
    else if (int'(s) >= RTC_BASE && int'(s) <= RTC_LAST) return SK_RTC;
    else                                              return SK_OFF;
  endfunction

  function automatic logic [RTC_IDX_W-1:0] f_rtc_index(input logic [SEL_W-1:0] s);
    int d;
    d = int'(s) - RTC_BASE;
    return d[RTC_IDX_W-1:0];
  endfunction

  always_comb begin
    rgn     = f_region(cpu_addr);
    kind    = f_kind(sel_q);
    any_acc = cpu_rd | cpu_wr;
    xw_hit  = (rgn == RGN_XWIN) && any_acc;
  end

  // ROM path: fixed area always bank zero, switchable area uses the register
  generate
    if (ROM_PAGE_AW < 16) begin : g_rom
      always_comb begin
        rom_cs = cpu_rd && (rgn == RGN_ROM_FIX || rgn == RGN_ROM_SW);
        if (rgn == RGN_ROM_SW)
          rom_addr = {rom_bank_eff, cpu_addr[ROM_PAGE_AW-1:0]};
        else
          rom_addr = {{ROM_BANK_W{1'b0}}, cpu_addr[ROM_PAGE_AW-1:0]};
      end
    end else begin : g_rom_bad
      assign rom_cs   = 1'b0;
      assign rom_addr = '0;
    end
  endgenerate

  // External window routing
  always_comb begin
    ram_addr = {sel_q[RAM_BANK_W-1:0], cpu_addr[RAM_PAGE_AW-1:0]};
    ram_en   = xw_hit && xw_enable_q && (kind == SK_RAM);
    rtc_stb  = xw_hit && xw_enable_q && (kind == SK_RTC);
    rtc_idx  = (kind == SK_RTC) ? f_rtc_index(sel_q) : '0;
    xw_ff    = cpu_rd && (rgn == RGN_XWIN) && (!xw_enable_q || kind == SK_OFF);
  end

endmodule

// File: rtl/cbm_mapper.sv
module cbm_mapper #(
  parameter int ROM_BANK_W  = 7,
  parameter int ROM_PAGE_AW = 14,
  parameter int RAM_BANK_W  = 3,
  parameter int RAM_PAGE_AW = 13,
  parameter int SEL_W       = 4,
  parameter int RTC_REGS    = 5,
  localparam int ROM_AW     = ROM_BANK_W + ROM_PAGE_AW,
  localparam int RAM_AW     = RAM_BANK_W + RAM_PAGE_AW,
  localparam int RTC_IDX_W  = (RTC_REGS > 1) ? $clog2(RTC_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cpu_addr,
  input  logic [7:0]           cpu_wdata,
  input  logic                 cpu_wr,
  input  logic                 cpu_rd,
  output logic                 rom_cs,
  output logic [ROM_AW-1:0]    rom_addr,
  output logic                 ram_en,
  output logic [RAM_AW-1:0]    ram_addr,
  output logic [RTC_IDX_W-1:0] rtc_idx,
  output logic                 rtc_stb,
  output logic                 xw_ff
);

  // Named internal events, brought out for the checker
  logic                  we_enable;
  logic                  we_rombank;
  logic                  we_select;
  logic                  we_latch;
  logic                  xw_hit;
  logic [ROM_BANK_W-1:0] rom_bank_eff;
  logic [SEL_W-1:0]      sel_q;
  logic                  xw_enable_q;

  cbm_wdec u_wdec (
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .we_enable  (we_enable),
    .we_rombank (we_rombank),
    .we_select  (we_select),
    .we_latch   (we_latch)
  );

  cbm_regs #(
    .ROM_BANK_W (ROM_BANK_W),
    .SEL_W      (SEL_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdata        (cpu_wdata),
    .we_enable    (we_enable),
    .we_rombank   (we_rombank),
    .we_select    (we_select),
    .rom_bank_eff (rom_bank_eff),
    .sel_q        (sel_q),
    .xw_enable_q  (xw_enable_q)
  );

  cbm_xlate #(
    .ROM_BANK_W  (ROM_BANK_W),
    .ROM_PAGE_AW (ROM_PAGE_AW),
    .RAM_BANK_W  (RAM_BANK_W),
    .RAM_PAGE_AW (RAM_PAGE_AW),
    .SEL_W       (SEL_W),
    .RTC_REGS    (RTC_REGS)
  ) u_xlate (
    .cpu_addr     (cpu_addr),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .rom_bank_eff (rom_bank_eff),
    .sel_q        (sel_q),
    .xw_enable_q  (xw_enable_q),
    .rom_cs       (rom_cs),
    .rom_addr     (rom_addr),
    .ram_en       (ram_en),
    .ram_addr     (ram_addr),
    .rtc_idx      (rtc_idx),
    .rtc_stb      (rtc_stb),
    .xw_ff        (xw_ff),
    .xw_hit       (xw_hit)
  );

endmodule

// File: rtl/cbm_mapper_chk.sv
module cbm_mapper_chk #(
  parameter int ROM_BANK_W  = 7,
  parameter int ROM_PAGE_AW = 14,
  parameter int SEL_W       = 4,
  parameter int RTC_IDX_W   = 3,
  parameter int RTC_REGS    = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [15:0]                   cpu_addr,
  input logic [7:0]                    cpu_wdata,
  input logic                          cpu_wr,
  input logic                          cpu_rd,
  input logic                          rom_cs,
  input logic [ROM_BANK_W+ROM_PAGE_AW-1:0] rom_addr,
  input logic                          ram_en,
  input logic [RTC_IDX_W-1:0]          rtc_idx,
  input logic                          rtc_stb,
  input logic                          xw_ff,
  input logic                          we_enable,
  input logic                          we_rombank,
  input logic                          we_select,
  input logic                          we_latch,
  input logic [ROM_BANK_W-1:0]         rom_bank_eff,
  input logic [SEL_W-1:0]              sel_q,
  input logic                          xw_enable_q
);

  logic in_fix, in_sw;
  assign in_fix = cpu_addr[15:14] == 2'b00;
  assign in_sw  = cpu_addr[15:14] == 2'b01;

  AST_FIXED_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs && in_fix) |-> (rom_addr[ROM_BANK_W+ROM_PAGE_AW-1:ROM_PAGE_AW] == '0)); // R2

  AST_SWITCH_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs && in_sw) |-> (rom_addr[ROM_BANK_W+ROM_PAGE_AW-1:ROM_PAGE_AW] != '0)); // R4

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rombank && cpu_wdata[ROM_BANK_W-1:0] != '0)
      |=> (rom_bank_eff == $past(cpu_wdata[ROM_BANK_W-1:0]))); // R3

  AST_ENABLE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    we_enable |=> (xw_enable_q == ($past(cpu_wdata[3:0]) == 4'hA))); // R5

  AST_RTC_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_stb |-> (int'(rtc_idx) < RTC_REGS)); // R7

  AST_RAM_RTC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_en && rtc_stb)); // R7

  AST_OPEN_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    xw_ff |-> (!ram_en && !rtc_stb)); // R8

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && (we_latch || cpu_addr[15]))
      |=> ($stable(rom_bank_eff) && $stable(sel_q) && $stable(xw_enable_q))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr) |-> (!rom_cs && !ram_en && !rtc_stb && !xw_ff)); // R10

endmodule

bind cbm_mapper cbm_mapper_chk #(
  .ROM_BANK_W  (ROM_BANK_W),
  .ROM_PAGE_AW (ROM_PAGE_AW),
  .SEL_W       (SEL_W),
  .RTC_IDX_W   (RTC_IDX_W),
  .RTC_REGS    (RTC_REGS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .cpu_wr       (cpu_wr),
  .cpu_rd       (cpu_rd),
  .rom_cs       (rom_cs),
  .rom_addr     (rom_addr),
  .ram_en       (ram_en),
  .rtc_idx      (rtc_idx),
  .rtc_stb      (rtc_stb),
  .xw_ff        (xw_ff),
  .we_enable    (we_enable),
  .we_rombank   (we_rombank),
  .we_select    (we_select),
  .we_latch     (we_latch),
  .rom_bank_eff (rom_bank_eff),
  .sel_q        (sel_q),
  .xw_enable_q  (xw_enable_q)
);

// File: tb/cbm_mapper_bench.sv
module cbm_mapper_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic        rom_cs;
  logic [20:0] rom_addr;
  logic        ram_en;
  logic [15:0] ram_addr;
  logic [2:0]  rtc_idx;
  logic        rtc_stb;
  logic        xw_ff;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench-side model of the control state
  int m_bank = 1;
  int m_sel  = 0;
  bit m_en   = 1'b0;

  always #4 clk = ~clk;

  cbm_mapper u_cbm_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_cs(rom_cs), .rom_addr(rom_addr),
    .ram_en(ram_en), .ram_addr(ram_addr), .rtc_idx(rtc_idx), .rtc_stb(rtc_stb),
    .xw_ff(xw_ff)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    cpu_addr = a[15:0]; cpu_wdata = d[7:0]; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a < 'h2000) m_en = (d % 16) == 'hA;
    else if (a < 'h4000) m_bank = ((d % 128) == 0) ? 1 : (d % 128);
    else if (a < 'h6000) m_sel = d % 16;
  endtask

  // Present an access, hold it, and sample mid-cycle
  task automatic present(input int a, input bit rd, input bit wr);
    @(negedge clk);
    cpu_addr = a[15:0]; cpu_rd = rd; cpu_wr = wr;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic check_window(input string req, input int a, input bit rd);
    bit served_ram, served_rtc;
    present(a, rd, !rd);
    served_ram = m_en && m_sel < 8;
    served_rtc = m_en && m_sel >= 8 && m_sel <= 12;
    chk({req, " ram_en"}, ram_en, served_ram);
    chk({req, " rtc_stb"}, rtc_stb, served_rtc);
    chk({req, " xw_ff"}, xw_ff, rd && !served_ram && !served_rtc);
    if (served_ram) chk({req, " ram_addr"}, ram_addr, (m_sel % 8) * 'h2000 + (a % 'h2000));
    if (served_rtc) chk({req, " rtc_idx"}, rtc_idx, m_sel - 8);
    idle();
  endtask

  task automatic check_rom_sw(input string req, input int a);
    present(a, 1'b1, 1'b0);
    chk({req, " rom_cs"}, rom_cs, 1);
    chk({req, " rom_addr"}, rom_addr, m_bank * 'h4000 + (a % 'h4000));
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state and R10 idle outputs
    #1;
    chk("R10 idle rom_cs", rom_cs, 0);
    chk("R10 idle ram_en", ram_en, 0);
    chk("R10 idle rtc_stb", rtc_stb, 0);
    chk("R10 idle xw_ff", xw_ff, 0);
    check_rom_sw("R1 reset bank", 'h4000);
    check_window("R1 reset disabled", 'hA000, 1'b1);
    bus_write('h0000, 'h0A);
    check_window("R1 reset select0", 'hA5A5, 1'b1);
    bus_write('h0000, 'h00);

    // R2 fixed area under different bank values
    for (int b = 0; b < 3; b++) begin
      bus_write('h2000, b * 'h33);
      for (int a = 0; a < 'h4000; a += 'h0FFF) begin
        present(a, 1'b1, 1'b0);
        chk("R2 rom_cs", rom_cs, 1);
        chk("R2 rom_addr", rom_addr, a);
        idle();
      end
      present('h3FFF, 1'b1, 1'b0);
      chk("R2 top rom_addr", rom_addr, 'h3FFF);
      idle();
    end

    // R3 and R4: every bank value, bit 7 set on odd values
    for (int v = 0; v < 128; v++) begin
      bus_write('h2000 + v * 37 % 'h2000, v + ((v % 2) * 128));
      check_rom_sw((v == 0) ? "R4 zero bank" : "R3 bank", 'h4000);
      check_rom_sw("R3 bank top", 'h7FFF);
    end
    bus_write('h3FFF, 'h20); check_rom_sw("R3 bank 0x20", 'h5123);
    bus_write('h2ABC, 'h40); check_rom_sw("R3 bank 0x40", 'h6123);
    bus_write('h2001, 'h60); check_rom_sw("R3 bank 0x60", 'h7123);

    // R5 enable key over all low nibbles, with changing upper nibbles
    bus_write('h4000, 3);
    for (int n = 0; n < 16; n++) begin
      bus_write('h0000 + n * 'h01F3, ((n * 5) % 16) * 16 + n);
      present('hB000, 1'b1, 1'b0);
      chk("R5 enable", ram_en, n == 'hA);
      chk("R5 open bus", xw_ff, n != 'hA);
      idle();
    end

    // R6 R7 R8: every select value, reads and writes at three addresses
    bus_write('h1FFF, 'hFA);
    for (int s = 0; s < 16; s++) begin
      bus_write('h4000 + s * 'h0111, 'hF0 + s);
      check_window((s < 8) ? "R6 ram" : (s < 13) ? "R7 rtc" : "R8 off", 'hA000, 1'b1);
      check_window((s < 8) ? "R6 ram" : (s < 13) ? "R7 rtc" : "R8 off", 'hB123, 1'b0);
      check_window((s < 8) ? "R6 ram" : (s < 13) ? "R7 rtc" : "R8 off", 'hBFFF, 1'b1);
    end
    // R8 disabled window ignores write and read for RAM and clock selects
    bus_write('h4000, 'h09);
    bus_write('h0000, 'h0B);
    check_window("R8 disabled rtc", 'hA001, 1'b0);
    check_window("R8 disabled rtc", 'hA001, 1'b1);

    // R9: stray writes leave state unchanged
    bus_write('h0000, 'h0A);
    bus_write('h4000, 'h05);
    bus_write('h2000, 'h11);
    bus_write('h6000, 'h00);
    bus_write('h7FFF, 'h01);
    bus_write('hA000, 'h00);
    bus_write('hBFFF, 'h0B);
    check_rom_sw("R9 bank kept", 'h4321);
    check_window("R9 sel and enable kept", 'hA777, 1'b1);

    // R10: outside the mapped areas nothing fires
    present('h8000, 1'b1, 1'b0);
    chk("R10 video rom_cs", rom_cs, 0);
    chk("R10 video ram_en", ram_en, 0);
    chk("R10 video xw_ff", xw_ff, 0);
    idle();
    present('h4000, 1'b0, 1'b0);
    chk("R10 no strobe rom_cs", rom_cs, 0);
    idle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule